// File: doc/BRIEF.md
# DRAM Refresh and Power-Up Scheduler

This block paces the refresh traffic of a 512-row dynamic memory and holds off normal accesses until the device has been brought up. After reset it counts out a fixed startup pause, measured in system-clock cycles. It then asks the access controller for a set number of dummy refresh cycles. When the last of these has been acknowledged, it raises a ready flag. From that point on, normal traffic may start.

In normal operation an interval timer marks one refresh as owed every few microseconds, so that every row is covered within the retention window. Owed refreshes accumulate in a bounded backlog. The refresh request stays high while the backlog is non-empty, so a refresh delayed by a long host burst is served later and not lost. The access controller answers each refresh it performs with a one-cycle acknowledge.

For controllers that refresh by strobing a row address alone, the block also keeps a 9-bit row pointer. The pointer steps once for each accepted refresh while that mode is selected. When the device's internal counter is used instead, the pointer is left alone.

Top module: `rfsh_sched`

## Requirements
- R1: While reset is asserted, ref_req is 0, init_done is 0 and ref_row is 0.
- R2: ref_req and init_done stay 0 during the first PAUSE_CYC clock edges after reset is released.
- R3: On the PAUSE_CYC-th edge after reset release, ref_req rises. It then stays high, without a gap, until DUMMY_CNT acknowledges have been accepted.
- R4: init_done rises on the edge that accepts the DUMMY_CNT-th dummy acknowledge. It then stays high until the next reset.
- R5: Once init_done is high, one refresh becomes owed every INTERVAL clock edges. The first is owed INTERVAL edges after init_done rises.
- R6: The count of owed refreshes goes up by one for each owed refresh and down by one for each accepted acknowledge. When both happen on the same edge, the count is unchanged. After init_done, ref_req is 1 exactly when the count is non-zero.
- R7: The owed count never exceeds MAX_PEND. An owed refresh that arrives when the count is full, with no acknowledge on the same edge, is dropped.
- R8: An acknowledge is accepted only while ref_req is 1. An acknowledge given while ref_req is 0 changes neither ref_row nor the progress of the dummy sequence.
- R9: An accepted acknowledge with ras_only = 1 advances ref_row by one. With ras_only = 0, ref_row holds its value.
- R10: ref_row wraps from 511 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ras_only | input | 1 | 1: row-address-only refresh, pointer advances; 0: device-internal counter in use |
| ref_ack | input | 1 | One-cycle acknowledge of a performed refresh |
| ref_req | output | 1 | Refresh wanted |
| init_done | output | 1 | Power-up sequence complete, normal accesses allowed |
| ref_row | output | 9 | Row to refresh in row-address-only mode |

## Verification
The bound checker watches, on every cycle, several properties that need only local history. It checks the quiet pause after reset and that the ready flag, once set, stays set. It checks that the ready flag can only rise on an accepted acknowledge, and that the request cannot drop unless an acknowledge was accepted. It also checks the exact step-or-hold behaviour of the row pointer. Other properties depend on the long-run pacing and need the bench's reference model and scenarios to show: the interval between owed refreshes, the exact number of dummy cycles, the backlog filling to saturation under a long idle acknowledge line, and the pointer wrapping after hundreds of refreshes.

// File: rtl/rfsh_pkg.sv
package rfsh_pkg;
  typedef enum logic [1:0] {
    PH_PAUSE = 2'd0,
    PH_DUMMY = 2'd1,
    PH_RUN   = 2'd2
  } rfsh_phase_e;
endpackage

// File: rtl/rfsh_seq.sv
// Power-up phase controller: quiet pause, then dummy refreshes, then run.
module rfsh_seq
  import rfsh_pkg::*;
#(
  parameter int PAUSE_CYC = 25600,
  parameter int DUMMY_CNT = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ack_ok,
  output rfsh_phase_e phase
);
  localparam int PW = (PAUSE_CYC > 2) ? $clog2(PAUSE_CYC) : 1;
  localparam int DW = (DUMMY_CNT > 1) ? $clog2(DUMMY_CNT + 1) : 1;

  rfsh_phase_e   phase_q, phase_d;
  logic [PW-1:0] pcnt_q, pcnt_d;
  logic [DW-1:0] dcnt_q, dcnt_d;
  logic          pcnt_en, dcnt_en;

  always_comb begin
    phase_d = phase_q;
    pcnt_d  = pcnt_q + PW'(1);
    dcnt_d  = dcnt_q + DW'(1);
    pcnt_en = 1'b0;
    dcnt_en = 1'b0;
    unique case (phase_q)
      PH_PAUSE: begin
        pcnt_en = 1'b1;
        if (pcnt_q == PW'(PAUSE_CYC - 1)) begin
          phase_d = PH_DUMMY;
          pcnt_d  = '0;
        end
      end
      PH_DUMMY: begin
        dcnt_en = ack_ok;
        if (ack_ok && (dcnt_q == DW'(DUMMY_CNT - 1))) phase_d = PH_RUN;
      end
      default: phase_d = PH_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_PAUSE;
      pcnt_q  <= '0;
      dcnt_q  <= '0;
    end else begin
      phase_q <= phase_d;
      if (pcnt_en) pcnt_q <= pcnt_d;
      if (dcnt_en) dcnt_q <= dcnt_d;
    end
  end

  assign phase = phase_q;
endmodule

// File: rtl/rfsh_timer.sv
// Interval timer: one tick every INTERVAL enabled cycles.
module rfsh_timer #(
  parameter int INTERVAL = 3900
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic tick
);
  localparam int TW = (INTERVAL > 2) ? $clog2(INTERVAL) : 1;

  logic [TW-1:0] tmr_q, tmr_d;
  logic          at_end;

  assign at_end = (tmr_q == TW'(INTERVAL - 1));
  assign tick   = en && at_end;

  always_comb begin
    tmr_d = at_end ? '0 : tmr_q + TW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tmr_q <= '0;
    else if (en) tmr_q <= tmr_d;
  end
endmodule

// File: rtl/rfsh_backlog.sv
// Saturating count of refreshes owed but not yet performed.
module rfsh_backlog #(
  parameter int MAX_PEND = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic take,
  output logic owed
);
  localparam int CW = $clog2(MAX_PEND + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          full, cnt_en;

  assign full = (cnt_q == CW'(MAX_PEND));

  always_comb begin
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    if (tick && !take && !full) begin
      cnt_d  = cnt_q + CW'(1);
      cnt_en = 1'b1;
    end else if (take && !tick && (cnt_q != '0)) begin
      cnt_d  = cnt_q - CW'(1);
      cnt_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign owed = (cnt_q != '0);
endmodule

// File: rtl/rfsh_row.sv
// Row pointer for row-address-only refresh.
module rfsh_row #(
  parameter int ROW_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  output logic [ROW_W-1:0] row
);
  logic [ROW_W-1:0] row_q, row_d;

  always_comb row_d = row_q + ROW_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) row_q <= '0;
    else if (step) row_q <= row_d;
  end

  assign row = row_q;
endmodule

// File: rtl/rfsh_sched.sv
// Top: refresh and power-up scheduler.
module rfsh_sched
  import rfsh_pkg::*;
#(
  parameter int PAUSE_CYC = 25600,
  parameter int INTERVAL  = 3900,
  parameter int DUMMY_CNT = 8,
  parameter int MAX_PEND  = 8,
  parameter int ROW_W     = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ras_only,
  input  logic             ref_ack,
  output logic             ref_req,
  output logic             init_done,
  output logic [ROW_W-1:0] ref_row
);
  rfsh_phase_e phase;
  logic        ack_ok, tick, owed, in_run;

  assign in_run    = (phase == PH_RUN);
  assign ref_req   = (phase == PH_DUMMY) || (in_run && owed);
  assign ack_ok    = ref_req && ref_ack;
  assign init_done = in_run;

  rfsh_seq #(.PAUSE_CYC(PAUSE_CYC), .DUMMY_CNT(DUMMY_CNT)) u_seq (
    .clk(clk), .rst_n(rst_n), .ack_ok(ack_ok), .phase(phase)
  );

  rfsh_timer #(.INTERVAL(INTERVAL)) u_timer (
    .clk(clk), .rst_n(rst_n), .en(in_run), .tick(tick)
  );

  rfsh_backlog #(.MAX_PEND(MAX_PEND)) u_backlog (
    .clk(clk), .rst_n(rst_n), .tick(tick), .take(ack_ok && in_run), .owed(owed)
  );

  rfsh_row #(.ROW_W(ROW_W)) u_row (
    .clk(clk), .rst_n(rst_n), .step(ack_ok && ras_only), .row(ref_row)
  );
endmodule

// File: rtl/rfsh_sched_chk.sv
module rfsh_sched_chk #(
  parameter int PAUSE_CYC = 25600,
  parameter int ROW_W     = 9
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ras_only,
  input logic             ref_ack,
  input logic             ref_req,
  input logic             init_done,
  input logic [ROW_W-1:0] ref_row
);
  logic [31:0] since_rst;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) since_rst <= '0;
    else if (since_rst < 32'(PAUSE_CYC)) since_rst <= since_rst + 32'd1;
  end

  a_r2_quiet_pause: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst < 32'(PAUSE_CYC)) |-> (!ref_req && !init_done));

  a_r4_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |=> init_done);

  a_r4_done_on_ack: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(init_done) |-> $past(ref_req && ref_ack));

  a_r3_req_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_req && !ref_ack) |=> ref_req);

  a_r9_row_step: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_req && ref_ack && ras_only) |=> (ref_row == $past(ref_row) + ROW_W'(1)));

  a_r8_row_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(ref_req && ref_ack && ras_only) |=> $stable(ref_row));
endmodule

bind rfsh_sched rfsh_sched_chk #(.PAUSE_CYC(PAUSE_CYC), .ROW_W(ROW_W)) u_chk (.*);

// File: tb/rfsh_sched_bench.sv
`timescale 1ns/1ps
module rfsh_sched_bench;
  localparam int PAUSE_CYC = 50;
  localparam int INTERVAL  = 20;
  localparam int DUMMY_CNT = 8;
  localparam int MAX_PEND  = 4;

  logic       clk, rst_n, ras_only, ref_ack;
  logic       ref_req, init_done;
  logic [8:0] ref_row;

  int checks = 0, failures = 0, cycles = 0, wraps = 0, prev_row = 0;
  int m_phase, m_pcnt, m_dcnt, m_tmr, m_pend, m_row;

  rfsh_sched #(.PAUSE_CYC(PAUSE_CYC), .INTERVAL(INTERVAL), .DUMMY_CNT(DUMMY_CNT),
               .MAX_PEND(MAX_PEND), .ROW_W(9)) u_rfsh_sched (
    .clk(clk), .rst_n(rst_n), .ras_only(ras_only), .ref_ack(ref_ack),
    .ref_req(ref_req), .init_done(init_done), .ref_row(ref_row)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic bit f_req(int ph, int pend);
    return (ph == 1) || (ph == 2 && pend != 0);
  endfunction

  function automatic int f_pend(int pend, bit tick, bit take);
    int n = pend + (tick ? 1 : 0) - (take ? 1 : 0);
    return (n > MAX_PEND) ? MAX_PEND : n;
  endfunction

  // Reference model built from R2..R10
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_phase = 0; m_pcnt = 0; m_dcnt = 0; m_tmr = 0; m_pend = 0; m_row = 0;
    end else begin
      bit acc, tick;
      acc  = ref_ack && f_req(m_phase, m_pend);
      tick = 1'b0;
      if (acc && ras_only) m_row = (m_row + 1) % 512;
      case (m_phase)
        0: begin
          m_pcnt++;
          if (m_pcnt == PAUSE_CYC) m_phase = 1;
        end
        1: if (acc) begin
          m_dcnt++;
          if (m_dcnt == DUMMY_CNT) m_phase = 2;
        end
        default: begin
          m_tmr++;
          if (m_tmr == INTERVAL) begin m_tmr = 0; tick = 1'b1; end
          m_pend = f_pend(m_pend, tick, acc);
        end
      endcase
    end
  end

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s act=%0d exp=%0d cycle=%0d", tag, what, act, exp, cycles);
    end
  endtask

  task automatic compare();
    string tq;
    if (!rst_n) begin
      chk("R1", "ref_req", ref_req, 0);
      chk("R1", "init_done", init_done, 0);
      chk("R1", "ref_row", ref_row, 0);
    end else begin
      if (m_phase == 0) tq = "R2";
      else if (m_phase == 1) tq = "R3";
      else if (m_pend == MAX_PEND) tq = "R7";
      else tq = "R5/R6";
      chk(tq, "ref_req", ref_req, int'(f_req(m_phase, m_pend)));
      chk((m_phase == 0) ? "R2" : "R4", "init_done", init_done, int'(m_phase == 2));
      chk("R8/R9", "ref_row", ref_row, m_row);
      if (prev_row == 511 && ref_row == 0) wraps++;
      prev_row = ref_row;
    end
  endtask

  task automatic step(bit ack, bit mode);
    @(negedge clk);
    compare();
    ref_ack  = ack;
    ras_only = mode;
  endtask

  task automatic rand_run(int n, int ack_pct, bit rand_mode);
    for (int i = 0; i < n; i++)
      step(($urandom % 100) < ack_pct, rand_mode ? 1'($urandom % 2) : 1'b1);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      failures++;
      $display("FAIL watchdog expired cycle=%0d", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 1'b0; ref_ack = 1'b0; ras_only = 1'b1;
    for (int i = 0; i < 3; i++) step(1'b1, 1'b1);   // R1 with ack driven
    @(negedge clk); rst_n = 1'b1; ref_ack = 1'b0;
    // R2/R8: acks during the pause must be ignored
    rand_run(PAUSE_CYC + 2, 50, 1'b0);
    // R3/R4: dummy sequence with sparse acks
    rand_run(60, 30, 1'b0);
    // R7: long idle fills the backlog past its limit
    rand_run(INTERVAL * (MAX_PEND + 3), 0, 1'b0);
    // R5/R6: mixed traffic, both refresh modes
    rand_run(3000, 12, 1'b1);
    // R10: continuous acks drive the pointer through a wrap
    rand_run(11000, 100, 1'b0);
    // R1: reset in the middle of operation, then restart
    @(negedge clk); rst_n = 1'b0;
    step(1'b0, 1'b1); step(1'b0, 1'b1);
    @(negedge clk); rst_n = 1'b1;
    rand_run(PAUSE_CYC + 200, 40, 1'b1);
    chk("R10", "wraps seen", int'(wraps > 0), 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule